// File: doc/BRIEF.md
# Sized-Access Byte Memory

A byte-addressed storage block that serves loads and stores of one, two or four bytes through a 24-bit address. One request may be presented per clock. It is qualified by an enable and carries a load/store select, a two-bit size code, an address and write data. Multi-byte values are put together big-endian: the byte at the lowest address goes to the most significant position. Word and long-word requests must be naturally aligned. A misaligned request, or a request that uses the reserved size code, is refused and flagged.

Load results come back one clock after the request on a 32-bit read port. An output-enable marks the cycle in which the block would drive a shared data bus. Outside those cycles the read port is held at zero. Only the low `MEM_AW` address bits select a byte, so the implemented depth is 2^`MEM_AW` bytes, and higher addresses wrap onto it.

Top module: `sized_byte_mem`

## Requirements
- R1: `size_i` encodes the access size as 00 = one byte, 01 = two bytes and 11 = four bytes. Code 10 is reserved: the request sets `err_o` one cycle later, writes nothing, and reads as zero.
- R2: Byte order is big-endian. The byte at the lowest address of a multi-byte access occupies bits 31:24 of a four-byte value and bits 15:8 of a two-byte value. For example, a four-byte store of 0x11223344 at address 0 followed by byte loads at addresses 0 and 3 returns 0x11 and 0x44.
- R3: A one-byte read appears in `rdata_o[7:0]` and a two-byte read in `rdata_o[15:0]`, with all higher bits zero. A store takes its byte from `wdata_i[7:0]` or its two bytes from `wdata_i[15:0]`, and ignores the rest of `wdata_i`.
- R4: While `en_i` is 0, every other input is ignored. No location changes, and in the next cycle `rdata_oe_o` and `err_o` are 0.
- R5: An enabled load raises `rdata_oe_o` in the next cycle, and the result is on `rdata_o` in that same cycle.
- R6: A two-byte access at an odd address, or a four-byte access whose address bits 1:0 are not 00, raises `err_o` in the next cycle. Such an access writes nothing, and if it is a load it returns zero.
- R7: Requests take effect one at a time, in issue order. A later store replaces an earlier value. A load issued in the cycle right after a store to the same bytes returns the newly stored value.
- R8: After reset, every location reads as zero, and `rdata_o`, `rdata_oe_o` and `err_o` are 0.
- R9: `rdata_oe_o` is never raised after a store or an idle cycle. Whenever `rdata_oe_o` is 0, `rdata_o` is zero.
- R10: Only address bits `MEM_AW`-1:0 select a location. An address that differs only in higher bits reaches the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Request enable; when low, all other request inputs are ignored |
| rd_nwr_i | input | 1 | 1 = load, 0 = store |
| size_i | input | 2 | Access size code (00 byte, 01 two bytes, 11 four bytes, 10 reserved) |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 32 | Store data, right-aligned |
| rdata_o | output | 32 | Load result, right-aligned, one cycle after the request |
| rdata_oe_o | output | 1 | High in the cycle in which a load result is driven |
| err_o | output | 1 | High in the cycle after a misaligned or reserved-size request |

## Verification
All three results (`rdata_o`, `rdata_oe_o` and `err_o`) are due exactly one rising edge after the request that causes them. A store's effect must be visible to a load issued on the very next edge. The bench applies each request at a falling edge and compares the outputs at the next falling edge against a byte-array model. That model already holds every earlier store, so the only rising edge in between is the one that registers the response. Each request therefore has exactly one comparison, made in the cycle when its response is due. Because requests go back to back, the store-then-load ordering is exercised at full rate.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam int LANES   = 4;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = LANES * BYTE_W;
  localparam int ADDR_W  = 24;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_RSVD = 2'b10,
    SZ_FULL = 2'b11
  } size_e;

  // Number of bytes moved by a size code; 0 marks the reserved code.
  function automatic int unsigned size_bytes(logic [1:0] code);
    case (code)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_FULL: return 4;
      default: return 0;
    endcase
  endfunction

  // Natural alignment test; the reserved code never passes.
  function automatic logic is_aligned(logic [1:0] code, logic [1:0] off);
    case (code)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~off[0];
      SZ_FULL: return off == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  // Lanes touched by an access; lane k holds the byte at row offset k.
  function automatic logic [LANES-1:0] lane_mask(logic [1:0] code, logic [1:0] off);
    logic [LANES-1:0] m;
    int unsigned n;
    int unsigned o;
    n = size_bytes(code);
    o = {30'd0, off};
    for (int unsigned k = 0; k < LANES; k++) begin
      m[k] = (k >= o) && (k < o + n);
    end
    return m;
  endfunction

  // Byte that a store places into a given lane (big-endian steering).
  function automatic logic [BYTE_W-1:0] store_byte(logic [1:0] code, logic [1:0] off,
                                                   int unsigned lane, logic [WORD_W-1:0] wd);
    int unsigned n;
    int unsigned o;
    int unsigned sh;
    n = size_bytes(code);
    o = {30'd0, off};
    if (n == 0 || lane < o || lane >= o + n) return '0;
    sh = BYTE_W * (n - 1 - (lane - o));
    return BYTE_W'(wd >> sh);
  endfunction

  // Right-aligned load value from a whole row given as {lane0,lane1,lane2,lane3}.
  function automatic logic [WORD_W-1:0] load_pack(logic [1:0] code, logic [1:0] off,
                                                  logic [WORD_W-1:0] row_bytes);
    int unsigned n;
    int unsigned o;
    int unsigned sh;
    logic [WORD_W-1:0] keep;
    n = size_bytes(code);
    o = {30'd0, off};
    if (n == 0 || o + n > LANES) return '0;
    sh   = BYTE_W * (LANES - o - n);
    keep = (n == LANES) ? '1 : ((WORD_W'(1) << (BYTE_W * n)) - WORD_W'(1));
    return (row_bytes >> sh) & keep;
  endfunction

endpackage

// File: rtl/smem_decode.sv
module smem_decode
  import smem_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic                         en_i,
  input  logic                         rd_nwr_i,
  input  logic [1:0]                   size_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic                         load_go_o,
  output logic                         fault_o,
  output logic [MEM_AW-3:0]            row_o,
  output logic [LANES-1:0]             lane_we_o,
  output logic [LANES-1:0][BYTE_W-1:0] lane_wd_o
);

  localparam int ROW_W = MEM_AW - 2;

  logic             store_go;
  logic [1:0]       off;
  logic [LANES-1:0] touched;

  assign off      = addr_i[1:0];
  assign row_o    = addr_i[ROW_W+1:2];
  assign touched  = lane_mask(size_i, off);

  assign fault_o   = en_i && !is_aligned(size_i, off);
  assign load_go_o = en_i &&  rd_nwr_i && !fault_o;
  assign store_go  = en_i && !rd_nwr_i && !fault_o;
  assign lane_we_o = store_go ? touched : '0;

  for (genvar k = 0; k < LANES; k++) begin : g_steer
    assign lane_wd_o[k] = store_byte(size_i, off, k, wdata_i);
  end

  if (MEM_AW < ADDR_W) begin : g_alias
    logic unused_hi_addr;
    assign unused_hi_addr = ^addr_i[ADDR_W-1:MEM_AW];
  end

endmodule

// File: rtl/smem_lane.sv
module smem_lane
  import smem_pkg::*;
#(
  parameter int ROWS_LOG2 = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [ROWS_LOG2-1:0] row_i,
  input  logic [BYTE_W-1:0]    wd_i,
  output logic [BYTE_W-1:0]    rd_o
);

  localparam int ROWS = 1 << ROWS_LOG2;

  logic [BYTE_W-1:0] cell_q [ROWS];
  logic [BYTE_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) cell_q[r] <= '0;
      rd_q <= '0;
    end else begin
      if (we_i) cell_q[row_i] <= wd_i;
      if (re_i) rd_q <= cell_q[row_i];
    end
  end

  assign rd_o = rd_q;

endmodule

// File: rtl/smem_pack.sv
module smem_pack
  import smem_pkg::*;
(
  input  logic                         load_q_i,
  input  logic                         err_q_i,
  input  logic [1:0]                   size_q_i,
  input  logic [1:0]                   off_q_i,
  input  logic [LANES-1:0][BYTE_W-1:0] lane_rd_i,
  output logic [WORD_W-1:0]            rdata_o,
  output logic                         oe_o
);

  logic [WORD_W-1:0] row_bytes;

  // Lane 0 is the lowest address, so it sits in the most significant byte.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      row_bytes[WORD_W-1-BYTE_W*k -: BYTE_W] = lane_rd_i[k];
    end
  end

  assign oe_o    = load_q_i;
  assign rdata_o = (load_q_i && !err_q_i) ? load_pack(size_q_i, off_q_i, row_bytes) : '0;

endmodule

// File: rtl/sized_byte_mem.sv
module sized_byte_mem
  import smem_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rd_nwr_i,
  input  logic [1:0]        size_i,
  input  logic [23:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rdata_oe_o,
  output logic              err_o
);

  localparam int ROW_W = MEM_AW - 2;

  // Named internal events, also observed by the checker.
  logic                         load_go;
  logic                         dec_fault;
  logic [ROW_W-1:0]             row;
  logic [LANES-1:0]             lane_we;
  logic [LANES-1:0][BYTE_W-1:0] lane_wd;
  logic [LANES-1:0][BYTE_W-1:0] lane_rd;

  logic       rsp_load_q;
  logic       rsp_err_q;
  logic [1:0] rsp_size_q;
  logic [1:0] rsp_off_q;

  smem_decode #(.MEM_AW(MEM_AW)) u_decode (
    .en_i      (en_i),
    .rd_nwr_i  (rd_nwr_i),
    .size_i    (size_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .load_go_o (load_go),
    .fault_o   (dec_fault),
    .row_o     (row),
    .lane_we_o (lane_we),
    .lane_wd_o (lane_wd)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    smem_lane #(.ROWS_LOG2(ROW_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (lane_we[k]),
      .re_i   (load_go),
      .row_i  (row),
      .wd_i   (lane_wd[k]),
      .rd_o   (lane_rd[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_load_q <= 1'b0;
      rsp_err_q  <= 1'b0;
      rsp_size_q <= '0;
      rsp_off_q  <= '0;
    end else begin
      rsp_load_q <= en_i && rd_nwr_i;
      rsp_err_q  <= dec_fault;
      if (en_i) begin
        rsp_size_q <= size_i;
        rsp_off_q  <= addr_i[1:0];
      end
    end
  end

  smem_pack u_pack (
    .load_q_i  (rsp_load_q),
    .err_q_i   (rsp_err_q),
    .size_q_i  (rsp_size_q),
    .off_q_i   (rsp_off_q),
    .lane_rd_i (lane_rd),
    .rdata_o   (rdata_o),
    .oe_o      (rdata_oe_o)
  );

  assign err_o = rsp_err_q;

endmodule

// File: rtl/smem_chk.sv
module smem_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        rd_nwr_i,
  input logic [31:0] rdata_o,
  input logic        rdata_oe_o,
  input logic        err_o,
  input logic        dec_fault,
  input logic [3:0]  lane_we
);

  // R4: an idle cycle produces no response
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rdata_oe_o && !err_o));

  // R5: an enabled load drives the bus on the following cycle
  a_r5_load_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_nwr_i) |=> rdata_oe_o);

  // R9: a store never drives the bus
  a_r9_store_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !rd_nwr_i) |=> !rdata_oe_o);

  // R9: read port is zero whenever it is not driven
  a_r9_zero_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == 32'h0));

  // R6: a refused request is flagged one cycle later and reads as zero
  a_r6_fault_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_fault |=> (err_o && rdata_o == 32'h0));

  // R1: a store touches one, two aligned, or all four lanes, never three
  a_r1_lane_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_we != 4'b0000) |-> ($onehot(lane_we) || lane_we == 4'b0011 ||
                              lane_we == 4'b1100 || lane_we == 4'b1111));

endmodule

bind sized_byte_mem smem_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .rd_nwr_i   (rd_nwr_i),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o),
  .err_o      (err_o),
  .dec_fault  (dec_fault),
  .lane_we    (lane_we)
);

// File: tb/sized_byte_mem_tb.sv
module sized_byte_mem_tb;

  localparam int MEM_AW = 8;
  localparam int DEPTH  = 1 << MEM_AW;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        rd_nwr_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [23:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rdata_oe_o;
  logic        err_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  byte unsigned model [DEPTH];

  always #5 clk_i = ~clk_i;

  sized_byte_mem #(.MEM_AW(MEM_AW)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .rd_nwr_i   (rd_nwr_i),
    .size_i     (size_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .rdata_oe_o (rdata_oe_o),
    .err_o      (err_o)
  );

  task automatic compare(input string tag, input logic eoe, input logic eerr, input logic [31:0] erd);
    vectors++;
    if (rdata_oe_o !== eoe || err_o !== eerr || rdata_o !== erd) begin
      miscompares++;
      $display("FAIL %s: got oe=%0b err=%0b rdata=%08h, expected oe=%0b err=%0b rdata=%08h",
               tag, rdata_oe_o, err_o, rdata_o, eoe, eerr, erd);
    end
  endtask

  // Apply one request at a falling edge; compare its response one cycle later.
  task automatic req(input string tag, input logic e, input logic rw, input logic [1:0] sz,
                     input logic [23:0] a, input logic [31:0] d);
    int n;
    int base;
    logic bad;
    logic [31:0] erd;
    n    = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b11) ? 4 : 0;
    base = int'(a) % DEPTH;
    bad  = (n == 0) || ((int'(a) % n) != 0);
    erd  = '0;
    if (e && !bad) begin
      if (rw) begin
        for (int i = 0; i < n; i++) erd = (erd << 8) | 32'(model[base + i]);
      end else begin
        for (int i = 0; i < n; i++) model[base + i] = byte'(d >> (8 * (n - 1 - i)));
      end
    end
    en_i = e; rd_nwr_i = rw; size_i = sz; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    compare(tag, e && rw, e && bad, erd);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    compare("R8 reset outputs", 1'b0, 1'b0, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R8 idle after reset", 1'b0, 1'b0, 32'h0);
    req("R8 zero contents", 1, 1, 2'b11, 24'h000080, 0);
    req("R8 zero contents", 1, 1, 2'b11, 24'h0000FC, 0);

    // single-byte ordering
    req("R7", 1, 0, 2'b00, 24'h0000FE, 32'h01);
    req("R7", 1, 0, 2'b00, 24'h0000FE, 32'h02);
    req("R7", 1, 1, 2'b00, 24'h0000FF, 0);
    req("R7", 1, 1, 2'b00, 24'h0000FE, 0);
    req("R7", 1, 0, 2'b00, 24'h0000FE, 32'h03);
    req("R7", 1, 1, 2'b01, 24'h0000FE, 0);

    // big-endian assembly
    req("R2", 1, 0, 2'b11, 24'h000000, 32'h11223344);
    req("R2", 1, 1, 2'b00, 24'h000000, 0);
    req("R2", 1, 1, 2'b00, 24'h000003, 0);
    req("R2", 1, 1, 2'b01, 24'h000000, 0);
    req("R2", 1, 1, 2'b01, 24'h000002, 0);
    req("R5", 1, 1, 2'b11, 24'h000000, 0);

    // right alignment, high write bits ignored
    req("R3", 1, 0, 2'b01, 24'h000006, 32'hABCD6251);
    req("R3", 1, 1, 2'b01, 24'h000006, 0);
    req("R3", 1, 1, 2'b00, 24'h000007, 0);
    req("R3", 1, 0, 2'b00, 24'h000005, 32'hFFFFFF5A);
    req("R3", 1, 1, 2'b11, 24'h000004, 0);

    // misalignment
    req("R6", 1, 0, 2'b01, 24'h000009, 32'h0000BEEF);
    req("R6", 1, 1, 2'b11, 24'h000008, 0);
    req("R6", 1, 1, 2'b01, 24'h000003, 0);
    req("R6", 1, 1, 2'b11, 24'h000002, 0);
    req("R6", 1, 0, 2'b11, 24'h00000D, 32'hDEADBEEF);
    req("R6", 1, 1, 2'b11, 24'h00000C, 0);

    // reserved size code
    req("R1", 1, 0, 2'b10, 24'h000000, 32'h99999999);
    req("R1", 1, 1, 2'b11, 24'h000000, 0);
    req("R1", 1, 1, 2'b10, 24'h000000, 0);

    // disabled cycles with junk on every other input
    for (int i = 0; i < 20; i++) begin
      req("R4", 0, i[0], 2'(i), 24'($urandom), $urandom);
    end
    req("R4", 1, 1, 2'b11, 24'h000000, 0);
    req("R4", 1, 1, 2'b11, 24'h000004, 0);

    // stores never drive the bus
    req("R9", 1, 0, 2'b11, 24'h000010, 32'h0BADCAFE);
    req("R9", 0, 1, 2'b11, 24'h000010, 0);
    req("R9", 1, 1, 2'b11, 24'h000010, 0);

    // high address bits alias
    req("R10", 1, 0, 2'b11, 24'h123440, 32'hCAFEF00D);
    req("R10", 1, 1, 2'b11, 24'h000040, 0);
    req("R10", 1, 1, 2'b00, 24'hFFFF43, 0);

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] a;
      a = 24'($urandom) & 24'hF000FF;
      req("R7 random", ($urandom % 5) != 0, $urandom % 2, 2'($urandom), a, $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule